// File: doc/BRIEF.md
# Tree Sum Reduction Engine

This block adds up a set of integer partial sums, one per processor slot, and returns a single total. It uses the halving scheme of a shared-memory multiprocessor. After each processor has summed its own slice, the number of live slots is halved in every round, and each surviving slot adds in the slot that sits half the live span above it. When the live count is odd, slot 0 also absorbs the element that would otherwise be stranded at the top. The tree is exact for any count; it does not assume a power of two.

A run begins with a start pulse that carries the number of partial sums. The engine then takes exactly that many values on a valid/ready input stream and stores them in slots 0, 1, 2, … in arrival order. A value moves only in a cycle where `in_valid` and `in_ready` are both high. The source may hold `in_valid` low for any number of cycles, and the engine simply waits. `in_ready` is high only while values are still expected. Each reduction round takes one clock cycle, and all of its additions read the values left by the previous round. When the run finishes, `done` pulses for one cycle and `total` carries the result.

Top module: `tree_sum_reduce`

## Requirements
- R1: After reset `done`, `busy` and `in_ready` are 0 and `total` is 0.
- R2: A start pulse while idle with a nonzero count raises `busy` and `in_ready`. Exactly that many values are then accepted, one per cycle in which `in_valid` and `in_ready` are both high, into slots 0 upward in arrival order. Cycles with `in_valid` low transfer nothing.
- R3: `total` equals the exact unsigned sum of the accepted values. The accumulator width is DATA_W plus ceil(log2(MAX_SLOTS)) bits, so even MAX_SLOTS full-scale inputs cannot overflow.
- R4: In every round where the live count is odd and at least 3, slot 0 receives its own value, its pairwise partner and the stranded top element in a single cycle. Odd counts therefore sum exactly.
- R5: With N values, `done` rises on rising edge floor(log2 N)+1 after the edge that accepts the last value. `busy` is low whenever `done` is high.
- R6: A start pulse with count 0 loads nothing: on that same edge `done` rises and `total` becomes 0.
- R7: A count above MAX_SLOTS is treated as MAX_SLOTS. `in_ready` drops after MAX_SLOTS values.
- R8: A start pulse while `busy` is high is ignored, and the running reduction is unaffected.
- R9: `done` lasts exactly one cycle. `total` changes only in a cycle where `done` is high and stays stable until then.
- R10: `in_valid` while the engine is idle has no effect: `in_ready` stays low and later results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run (ignored while busy) |
| count | input | CNT_W | Number of partial sums for the run |
| in_valid | input | 1 | Partial-sum value present on `in_data` |
| in_ready | output | 1 | Engine will accept a value this cycle |
| in_data | input | DATA_W | Unsigned partial sum |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle strobe: `total` is new |
| total | output | SUM_W | Result of the latest run |

## Verification
The hardest situation to reach is the three-term update of slot 0. In that round the odd fix-up and the pairwise add land together, and it happens only in certain rounds of certain counts, such as 3, 7 and 9. A dropped or duplicated term there is invisible with uniform data. The bench therefore sweeps every count from 0 to MAX_SLOTS, including one beyond it, on a small configuration. One pattern gives each slot its own distinct bit, so the total reveals exactly which slots were counted and how often. A full-scale pattern checks the accumulator width, and runs with input gaps and a mid-run start pulse cover back-pressure and the ignore rule.

// File: rtl/tsum_pkg.sv
package tsum_pkg;
  typedef enum logic [1:0] {
    TS_IDLE   = 2'd0,
    TS_LOAD   = 2'd1,
    TS_REDUCE = 2'd2
  } tsum_state_e;
endpackage

// File: rtl/tsum_ctrl.sv
module tsum_ctrl
  import tsum_pkg::*;
#(
  parameter int MAX_SLOTS = 100,
  parameter int CNT_W     = $clog2(MAX_SLOTS + 1),
  parameter int IDX_W     = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             busy,
  output logic             load_en,
  output logic [IDX_W-1:0] load_idx,
  output logic             round_en,
  output logic [CNT_W-1:0] half_now,
  output logic             finish,
  output logic             zero_run
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_SLOTS);

  tsum_state_e      state_q;
  logic [CNT_W-1:0] target_q;
  logic [CNT_W-1:0] half_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] eff_cnt;
  logic             last_in;

  assign eff_cnt  = (count > CNT_MAX) ? CNT_MAX : count;
  assign in_ready = (state_q == TS_LOAD);
  assign busy     = (state_q != TS_IDLE);
  assign load_en  = in_ready && in_valid;
  assign load_idx = idx_q;
  assign half_now = half_q;
  assign round_en = (state_q == TS_REDUCE) && (half_q != CNT_W'(1));
  assign finish   = (state_q == TS_REDUCE) && (half_q == CNT_W'(1));
  assign zero_run = (state_q == TS_IDLE) && start && (eff_cnt == '0);
  assign last_in  = (CNT_W'(idx_q) == target_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= TS_IDLE;
      target_q <= '0;
      half_q   <= '0;
      idx_q    <= '0;
    end else begin
      unique case (state_q)
        TS_IDLE: begin
          if (start && eff_cnt != '0) begin
            target_q <= eff_cnt;
            idx_q    <= '0;
            state_q  <= TS_LOAD;
          end
        end
        TS_LOAD: begin
          if (in_valid) begin
            idx_q <= idx_q + IDX_W'(1);
            if (last_in) begin
              half_q  <= target_q;
              state_q <= TS_REDUCE;
            end
          end
        end
        TS_REDUCE: begin
          if (half_q == CNT_W'(1)) state_q <= TS_IDLE;
          else                     half_q  <= half_q >> 1;
        end
        default: state_q <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsum_lanes.sv
module tsum_lanes #(
  parameter int MAX_SLOTS = 100,
  parameter int DATA_W    = 16,
  parameter int SUM_W     = DATA_W + $clog2(MAX_SLOTS),
  parameter int CNT_W     = $clog2(MAX_SLOTS + 1),
  parameter int IDX_W     = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [DATA_W-1:0] load_data,
  input  logic              round_en,
  input  logic [CNT_W-1:0]  half_now,
  output logic [SUM_W-1:0]  slot0
);
  logic [SUM_W-1:0] slot_q   [MAX_SLOTS];
  logic [SUM_W-1:0] slot_nxt [MAX_SLOTS];
  logic [CNT_W-1:0] next_half;
  logic [SUM_W-1:0] stray;

  assign next_half = half_now >> 1;
  assign slot0     = slot_q[0];

  // Element stranded at the top when the live count is odd.
  always_comb begin
    stray = '0;
    if (half_now[0] && half_now > CNT_W'(1))
      stray = slot_q[IDX_W'(half_now - CNT_W'(1))];
  end

  // One barrier-separated round: every read sees last round's values.
  always_comb begin
    for (int i = 0; i < MAX_SLOTS; i++) begin
      slot_nxt[i] = slot_q[i];
      if (CNT_W'(i) < next_half)
        slot_nxt[i] = slot_q[i] + slot_q[IDX_W'(i) + IDX_W'(next_half)];
    end
    slot_nxt[0] = slot_nxt[0] + stray;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_SLOTS; i++) slot_q[i] <= '0;
    end else if (load_en) begin
      slot_q[load_idx] <= SUM_W'(load_data);
    end else if (round_en) begin
      for (int i = 0; i < MAX_SLOTS; i++) slot_q[i] <= slot_nxt[i];
    end
  end
endmodule

// File: rtl/tree_sum_reduce.sv
module tree_sum_reduce #(
  parameter int MAX_SLOTS = 100,
  parameter int DATA_W    = 16,
  parameter int SUM_W     = DATA_W + $clog2(MAX_SLOTS),
  parameter int CNT_W     = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              busy,
  output logic              done,
  output logic [SUM_W-1:0]  total
);
  localparam int IDX_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

  logic             load_en;
  logic [IDX_W-1:0] load_idx;
  logic             round_en;
  logic [CNT_W-1:0] half_now;
  logic             finish;
  logic             zero_run;
  logic [SUM_W-1:0] slot0;

  tsum_ctrl #(.MAX_SLOTS(MAX_SLOTS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .in_valid(in_valid), .in_ready(in_ready), .busy(busy),
    .load_en(load_en), .load_idx(load_idx), .round_en(round_en),
    .half_now(half_now), .finish(finish), .zero_run(zero_run)
  );

  tsum_lanes #(.MAX_SLOTS(MAX_SLOTS), .DATA_W(DATA_W), .SUM_W(SUM_W),
               .CNT_W(CNT_W), .IDX_W(IDX_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .load_data(in_data), .round_en(round_en), .half_now(half_now),
    .slot0(slot0)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      total <= '0;
    end else begin
      done <= finish || zero_run;
      if (finish)        total <= slot0;
      else if (zero_run) total <= '0;
    end
  end
endmodule

// File: rtl/tsum_checker.sv
module tsum_checker #(
  parameter int MAX_SLOTS = 100,
  parameter int DATA_W    = 16,
  parameter int SUM_W     = DATA_W + $clog2(MAX_SLOTS),
  parameter int CNT_W     = $clog2(MAX_SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic             in_ready,
  input logic             busy,
  input logic             done,
  input logic [SUM_W-1:0] total
);
  localparam logic [SUM_W:0] SUM_CAP =
    (SUM_W+1)'(MAX_SLOTS) * (SUM_W+1)'((1 << DATA_W) - 1);

  // R3
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, total} <= SUM_CAP));
  // R5
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && count == '0) |=> (done && total == '0));
  // R8
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  // R9
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_total_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(total));
  // R10
  p_idle_no_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);
endmodule

bind tree_sum_reduce tsum_checker #(
  .MAX_SLOTS(MAX_SLOTS), .DATA_W(DATA_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .count(count),
  .in_ready(in_ready), .busy(busy), .done(done), .total(total)
);

// File: tb/tree_sum_reduce_test.sv
module tree_sum_reduce_test;
  localparam int MAXS  = 9;
  localparam int DW    = 12;
  localparam int SW    = DW + $clog2(MAXS);
  localparam int CW    = $clog2(MAXS + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] count = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          busy;
  logic          done;
  logic [SW-1:0] total;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  tree_sum_reduce #(.MAX_SLOTS(MAXS), .DATA_W(DW), .SUM_W(SW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .busy(busy), .done(done), .total(total)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int flog2(input int n);
    int r = 0;
    while (n > 1) begin n = n >> 1; r++; end
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input int p, input int k);
    case (p)
      0:       return DW'(1 << k);
      1:       return {DW{1'b1}};
      default: return DW'((k * 37 + 5) % (1 << DW));
    endcase
  endfunction

  task automatic run(input int req_n, input int p, input bit gaps, input bit poke);
    int eff = (req_n > MAXS) ? MAXS : req_n;
    longint exp = 0;
    int first = -1;
    @(negedge clk);
    start = 1'b1; count = CW'(req_n);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (eff == 0) begin
      check("R6 done on zero count", done, 1);
      check("R6 total on zero count", total, 0);
      @(negedge clk);
      check("R9 done one cycle", done, 0);
      return;
    end
    check("R2 ready after start", in_ready, 1);
    for (int k = 0; k < eff; k++) begin
      if (gaps) begin
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 ready held during gap", in_ready, 1);
      end
      in_valid = 1'b1; in_data = pat(p, k);
      exp += pat(p, k);
      if (poke && k == 1) begin start = 1'b1; count = CW'(1); end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    in_valid = 1'b0;
    check("R7 ready drops after last value", in_ready, 0);
    for (int c = 1; c < 40 && first < 0; c++) begin
      if (done) first = c;
      else @(negedge clk);
    end
    check("R5 done latency", first, flog2(eff) + 2);
    if (eff % 2 == 1 && eff >= 3) check("R4 odd count total", total, exp);
    else                          check("R3 total", total, exp);
    check("R5 not busy at done", busy, 0);
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    check("R9 total held", total, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done reset", done, 0);
    check("R1 busy reset", busy, 0);
    check("R1 ready reset", in_ready, 0);
    check("R1 total reset", total, 0);
    rst_n = 1'b1;
    // R10: input traffic while idle
    @(negedge clk);
    in_valid = 1'b1; in_data = 12'hABC;
    repeat (3) begin
      @(negedge clk);
      check("R10 no ready while idle", in_ready, 0);
    end
    in_valid = 1'b0;
    check("R10 total untouched", total, 0);
    for (int p = 0; p < 3; p++)
      for (int n = 0; n <= MAXS; n++)
        run(n, p, 1'b0, 1'b0);
    run(12, 1, 1'b0, 1'b0);          // R7 clamp, full scale
    run(12, 0, 1'b0, 1'b0);          // R7 clamp, distinct bits
    run(7, 0, 1'b1, 1'b0);           // R2 back-pressure gaps
    run(9, 2, 1'b0, 1'b1);           // R8 start while busy
    run(5, 0, 1'b1, 1'b1);           // R8 with gaps
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule